// File: doc/BRIEF.md
# Speculative Load Address Tracker

This block records loads that a compiler moved above stores that might write the same memory. Each such early load allocates an entry that holds its destination register number and the address it read. Every store then searches all live entries and kills any entry whose address falls in the same 8-byte block. Before the loaded value is used for real, a check names the destination register. The block answers in the same cycle whether the early value is still good.

A good check lets the value stand and frees the entry. A failed check always asks for a reload from memory. If the check is of the branching kind, it also asks for a jump to recovery code. The block only produces these decisions. Memory access, the reload and the recovery code all live elsewhere.

Top module: `spec_load_tracker`

## Requirements
- R1: After a synchronous active-low reset no entry is live. A check on any register then fails (hit 0, reload 1).
- R2: An accepted early load makes a later check on the same register succeed: `chk_hit_o`=1, `chk_reload_o`=0, `chk_branch_o`=0.
- R3: A check consumes the entry for its register whether it succeeds or not. A second check on that register fails.
- R4: A store kills an entry whose address matches in bits 63..3, so an offset within the same 8-byte block still kills it. A store whose address differs in bits 63..3 leaves the entry live.
- R5: On a failed check, `chk_kind_i`=0 gives reload only, and `chk_kind_i`=1 gives reload and branch.
- R6: An early load to a register that already has a live entry overwrites that entry. A store to the old address no longer affects it, and there is never more than one live entry per register.
- R7: When all 16 entries are live, a load to a new register evicts a slot chosen by a round-robin pointer that starts at slot 0 and advances once per eviction. An empty table fills from the lowest free slot.
- R8: A store and a check in the same cycle on the same block: the store wins and the check fails.
- R9: `flush_i` clears every entry in one cycle. An early load presented in the same cycle is dropped.
- R10: The check result is combinational and reflects the table before this cycle's load. A load and a check to the same register in one cycle give a failed check, and the new entry survives.
- R11: A store in the same cycle as an early load to the same block does not kill the new entry.
- R12: While `chk_valid_i` is 0, all three check outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush_i | input | 1 | Clear all entries |
| ld_valid_i | input | 1 | Early load present |
| ld_reg_i | input | 7 | Destination register of the early load |
| ld_addr_i | input | 64 | Address read by the early load |
| st_valid_i | input | 1 | Store present |
| st_addr_i | input | 64 | Store address |
| chk_valid_i | input | 1 | Check present |
| chk_reg_i | input | 7 | Register being checked |
| chk_kind_i | input | 1 | 0 = reload on failure, 1 = reload and branch on failure |
| chk_hit_o | output | 1 | Early value still valid |
| chk_reload_o | output | 1 | Reload from memory required |
| chk_branch_o | output | 1 | Jump to recovery code required |

## Verification
The table-driven part runs single-register sequences that tell apart the following cases:
- a clean hit and a consumed entry;
- a store inside the same 8-byte block and one just past it;
- an overwritten register whose old address is stored to;
- same-cycle pairs of store and check, store and load, and load and check.

Directed tests then fill all 16 slots and load two more registers. Checking which of the oldest registers vanished separates round-robin eviction from any other victim choice. Flush with a concurrent load, and a mid-run reset, show that the table empties and that the dropped load never lands.

// File: rtl/slt_pkg.sv
// Shared types for the speculative load address tracker.
// Assumes a single-bit check-kind field at the block boundary.
package slt_pkg;
    typedef enum logic {
        CHK_RELOAD = 1'b0,
        CHK_BRANCH = 1'b1
    } chk_kind_e;
endpackage

// File: rtl/slt_entry.sv
// One tracker slot: holds a live bit, a register tag and the load address.
// It reports register and block matches to the top.
// Assumes at most one write per cycle, selected by the slot picker.
module slt_entry #(
    parameter int REG_W    = 7,
    parameter int ADDR_W   = 64,
    parameter int GRAN_LSB = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              wr_i,
    input  logic [REG_W-1:0]  wr_reg_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic              st_valid_i,
    input  logic [ADDR_W-1:0] st_addr_i,
    input  logic              chk_valid_i,
    input  logic [REG_W-1:0]  chk_reg_i,
    output logic              valid_o,
    output logic              ld_hit_o,
    output logic              chk_hit_o,
    output logic              st_hit_o
);
    localparam logic [ADDR_W-1:0] BLK_MASK = {ADDR_W{1'b1}} << GRAN_LSB;

    logic              valid_q;
    logic [REG_W-1:0]  tag_q;
    logic [ADDR_W-1:0] addr_q;

    // Match terms seen by the top and by this slot's own update.
    always_comb begin
        ld_hit_o  = valid_q && (tag_q == wr_reg_i);
        chk_hit_o = valid_q && (tag_q == chk_reg_i);
        st_hit_o  = valid_q && st_valid_i && (((addr_q ^ st_addr_i) & BLK_MASK) == '0);
    end

    // Live bit: reset/flush first, then a new load, then store or check kill.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i)
            valid_q <= 1'b0;
        else if (wr_i)
            valid_q <= 1'b1;
        else if (st_hit_o || (chk_valid_i && chk_hit_o))
            valid_q <= 1'b0;
    end

    // Payload capture on allocation.
    always_ff @(posedge clk) begin
        if (wr_i) begin
            tag_q  <= wr_reg_i;
            addr_q <= wr_addr_i;
        end
    end

    assign valid_o = valid_q;

    // R2
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !flush_i) |=> (valid_o && tag_q == $past(wr_reg_i)));
    // R4
    store_kills_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_hit_o && !wr_i && !flush_i) |=> !valid_o);
    // R9
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> !valid_o);
endmodule

// File: rtl/slt_victim.sv
// Slot picker: reuses the slot already tagged with the load's register.
// Otherwise it takes the lowest free slot, or, when full, the round-robin
// victim. Assumes hit_vec_i has at most one bit set.
module slt_victim #(
    parameter int ENTRIES = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush_i,
    input  logic               ld_valid_i,
    input  logic [ENTRIES-1:0] valid_vec_i,
    input  logic [ENTRIES-1:0] hit_vec_i,
    output logic [ENTRIES-1:0] wr_vec_o
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0]   ptr_q;
    logic [ENTRIES-1:0] first_free;
    logic               full;
    logic               evict;

    // Lowest free slot as a one-hot vector.
    always_comb begin
        logic found;
        found      = 1'b0;
        first_free = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!valid_vec_i[i] && !found) begin
                first_free[i] = 1'b1;
                found         = 1'b1;
            end
        end
    end

    // Target selection for an accepted load.
    always_comb begin
        full     = &valid_vec_i;
        evict    = ld_valid_i && !flush_i && !(|hit_vec_i) && full;
        wr_vec_o = '0;
        if (ld_valid_i && !flush_i) begin
            if (|hit_vec_i)
                wr_vec_o = hit_vec_i;
            else if (!full)
                wr_vec_o = first_free;
            else
                wr_vec_o[ptr_q] = 1'b1;
        end
    end

    // Round-robin pointer advances only on an eviction.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (evict)
            ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end

    // R7
    one_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid_i && !flush_i) |-> ($countones(wr_vec_o) == 1));
    // R7
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !evict |=> $stable(ptr_q));
endmodule

// File: rtl/spec_load_tracker.sv
// Speculative load address tracker top. Early loads allocate slots, stores
// kill slots in the same address block, and checks consume slots and return
// a decision in the same cycle. Assumes one load, one store and one check
// at most per cycle.
module spec_load_tracker
    import slt_pkg::*;
#(
    parameter int ENTRIES  = 16,
    parameter int REG_W    = 7,
    parameter int ADDR_W   = 64,
    parameter int GRAN_LSB = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              ld_valid_i,
    input  logic [REG_W-1:0]  ld_reg_i,
    input  logic [ADDR_W-1:0] ld_addr_i,
    input  logic              st_valid_i,
    input  logic [ADDR_W-1:0] st_addr_i,
    input  logic              chk_valid_i,
    input  logic [REG_W-1:0]  chk_reg_i,
    input  logic              chk_kind_i,
    output logic              chk_hit_o,
    output logic              chk_reload_o,
    output logic              chk_branch_o
);
    logic [ENTRIES-1:0] valid_vec, ld_hit_vec, chk_hit_vec, st_hit_vec, wr_vec;
    chk_kind_e          kind;
    logic               good;

    slt_victim #(.ENTRIES(ENTRIES)) i_victim (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .ld_valid_i(ld_valid_i),
        .valid_vec_i(valid_vec), .hit_vec_i(ld_hit_vec), .wr_vec_o(wr_vec)
    );

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        slt_entry #(.REG_W(REG_W), .ADDR_W(ADDR_W), .GRAN_LSB(GRAN_LSB)) i_entry (
            .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .wr_i(wr_vec[g]),
            .wr_reg_i(ld_reg_i), .wr_addr_i(ld_addr_i),
            .st_valid_i(st_valid_i), .st_addr_i(st_addr_i),
            .chk_valid_i(chk_valid_i), .chk_reg_i(chk_reg_i),
            .valid_o(valid_vec[g]), .ld_hit_o(ld_hit_vec[g]),
            .chk_hit_o(chk_hit_vec[g]), .st_hit_o(st_hit_vec[g])
        );
    end

    // Check decision: a live tag match not killed by a same-cycle store.
    always_comb begin
        kind         = chk_kind_e'(chk_kind_i);
        good         = |(chk_hit_vec & ~st_hit_vec);
        chk_hit_o    = chk_valid_i && good;
        chk_reload_o = chk_valid_i && !good;
        chk_branch_o = chk_valid_i && !good && (kind == CHK_BRANCH);
    end

    // R6
    unique_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ld_hit_vec) <= 1);
    // R5
    branch_needs_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_branch_o |-> chk_reload_o);
    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid_i |-> !(chk_hit_o || chk_reload_o || chk_branch_o));
    // R9
    flush_clears_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (valid_vec == '0));
endmodule

// File: tb/test_spec_load_tracker.sv
`timescale 1ns/1ps
module test_spec_load_tracker;
    typedef struct packed {
        logic        ldv;
        logic [6:0]  ldr;
        logic [63:0] lda;
        logic        stv;
        logic [63:0] sta;
        logic        chv;
        logic [6:0]  chr;
        logic        chk;
        logic [2:0]  exp;   // {hit, reload, branch}
        logic [7:0]  req;
    } vec_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 1'b0;
    logic ld_valid = 1'b0, st_valid = 1'b0, chk_valid = 1'b0, chk_kind = 1'b0;
    logic [6:0]  ld_reg = '0, chk_reg = '0;
    logic [63:0] ld_addr = '0, st_addr = '0;
    logic chk_hit, chk_reload, chk_branch;
    int n_vec = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    spec_load_tracker i_spec_load_tracker (
        .clk(clk), .rst_n(rst_n), .flush_i(flush),
        .ld_valid_i(ld_valid), .ld_reg_i(ld_reg), .ld_addr_i(ld_addr),
        .st_valid_i(st_valid), .st_addr_i(st_addr),
        .chk_valid_i(chk_valid), .chk_reg_i(chk_reg), .chk_kind_i(chk_kind),
        .chk_hit_o(chk_hit), .chk_reload_o(chk_reload), .chk_branch_o(chk_branch)
    );

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 7'd5,  64'h0,   1'b0, 64'h0,   1'b1, 7'd5,  1'b0, 3'b010, 8'd1},  // R1 empty after reset
        '{1'b1, 7'd5,  64'h100, 1'b0, 64'h0,   1'b0, 7'd0,  1'b0, 3'b000, 8'd12}, // R12 no check, quiet
        '{1'b0, 7'd0,  64'h0,   1'b0, 64'h0,   1'b1, 7'd5,  1'b0, 3'b100, 8'd2},  // R2 hit
        '{1'b0, 7'd0,  64'h0,   1'b0, 64'h0,   1'b1, 7'd5,  1'b1, 3'b011, 8'd3},  // R3 consumed, R5 branch
        '{1'b1, 7'd6,  64'h200, 1'b0, 64'h0,   1'b0, 7'd0,  1'b0, 3'b000, 8'd12},
        '{1'b0, 7'd0,  64'h0,   1'b1, 64'h207, 1'b0, 7'd0,  1'b0, 3'b000, 8'd12},
        '{1'b0, 7'd0,  64'h0,   1'b0, 64'h0,   1'b1, 7'd6,  1'b1, 3'b011, 8'd4},  // R4 same block killed
        '{1'b1, 7'd7,  64'h300, 1'b0, 64'h0,   1'b0, 7'd0,  1'b0, 3'b000, 8'd12},
        '{1'b0, 7'd0,  64'h0,   1'b1, 64'h308, 1'b0, 7'd0,  1'b0, 3'b000, 8'd12},
        '{1'b0, 7'd0,  64'h0,   1'b0, 64'h0,   1'b1, 7'd7,  1'b0, 3'b100, 8'd4},  // R4 next block spared
        '{1'b1, 7'd8,  64'h400, 1'b0, 64'h0,   1'b0, 7'd0,  1'b0, 3'b000, 8'd12},
        '{1'b1, 7'd8,  64'h500, 1'b0, 64'h0,   1'b0, 7'd0,  1'b0, 3'b000, 8'd12},
        '{1'b0, 7'd0,  64'h0,   1'b1, 64'h400, 1'b0, 7'd0,  1'b0, 3'b000, 8'd12},
        '{1'b0, 7'd0,  64'h0,   1'b0, 64'h0,   1'b1, 7'd8,  1'b0, 3'b100, 8'd6},  // R6 overwritten
        '{1'b1, 7'd9,  64'h600, 1'b0, 64'h0,   1'b0, 7'd0,  1'b0, 3'b000, 8'd12},
        '{1'b0, 7'd0,  64'h0,   1'b1, 64'h600, 1'b1, 7'd9,  1'b0, 3'b010, 8'd8},  // R8 store wins
        '{1'b1, 7'd10, 64'h700, 1'b1, 64'h700, 1'b0, 7'd0,  1'b0, 3'b000, 8'd12},
        '{1'b0, 7'd0,  64'h0,   1'b0, 64'h0,   1'b1, 7'd10, 1'b0, 3'b100, 8'd11}, // R11 new entry kept
        '{1'b1, 7'd11, 64'h800, 1'b0, 64'h0,   1'b1, 7'd11, 1'b1, 3'b011, 8'd10}, // R10 sees old state
        '{1'b0, 7'd0,  64'h0,   1'b0, 64'h0,   1'b1, 7'd11, 1'b0, 3'b100, 8'd10}  // R10 load survived
    };

    // Drive one cycle of stimulus at the falling edge and compare just after.
    task automatic run(input vec_t v, input logic fl);
        @(negedge clk);
        ld_valid = v.ldv; ld_reg = v.ldr; ld_addr = v.lda;
        st_valid = v.stv; st_addr = v.sta;
        chk_valid = v.chv; chk_reg = v.chr; chk_kind = v.chk;
        flush = fl;
        #1;
        n_vec++;
        if ({chk_hit, chk_reload, chk_branch} !== v.exp) begin
            n_bad++;
            $display("FAIL R%0d: got %b expected %b (hit,reload,branch)",
                     v.req, {chk_hit, chk_reload, chk_branch}, v.exp);
        end
    endtask

    function automatic vec_t ld(input logic [6:0] r, input logic [63:0] a);
        return '{1'b1, r, a, 1'b0, 64'h0, 1'b0, 7'd0, 1'b0, 3'b000, 8'd12};
    endfunction

    function automatic vec_t ck(input logic [6:0] r, input logic [2:0] e, input logic [7:0] q);
        return '{1'b0, 7'd0, 64'h0, 1'b0, 64'h0, 1'b1, r, 1'b0, e, q};
    endfunction

    localparam vec_t IDLE = '{1'b0, 7'd0, 64'h0, 1'b0, 64'h0, 1'b0, 7'd0, 1'b0, 3'b000, 8'd12};

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        for (int i = 0; i < NV; i++) run(VECS[i], 1'b0);

        // R7: fill all 16 slots, then two more loads evict slots 0 and 1.
        for (int i = 0; i < 16; i++) run(ld(7'(20 + i), 64'h1000 + 64'(i) * 64'h40), 1'b0);
        run(ld(7'd40, 64'h2000), 1'b0);
        run(ld(7'd41, 64'h2040), 1'b0);
        run(ck(7'd20, 3'b010, 8'd7), 1'b0);   // R7 oldest evicted
        run(ck(7'd21, 3'b010, 8'd7), 1'b0);   // R7 second evicted
        run(ck(7'd22, 3'b100, 8'd7), 1'b0);   // R7 third kept
        run(ck(7'd40, 3'b100, 8'd7), 1'b0);
        run(ck(7'd41, 3'b100, 8'd7), 1'b0);

        // R9: flush with a concurrent load.
        run(ld(7'd50, 64'h3000), 1'b0);
        run(ld(7'd51, 64'h3040), 1'b1);
        run(ck(7'd50, 3'b010, 8'd9), 1'b0);   // R9 cleared
        run(ck(7'd51, 3'b010, 8'd9), 1'b0);   // R9 load dropped
        run(ck(7'd23, 3'b010, 8'd9), 1'b0);   // R9 older entries gone

        // R1: mid-run reset.
        run(ld(7'd60, 64'h4000), 1'b0);
        @(negedge clk) rst_n = 1'b0;
        run(IDLE, 1'b0);
        @(negedge clk) rst_n = 1'b1;
        run(ck(7'd60, 3'b010, 8'd1), 1'b0);   // R1 reset cleared

        run(IDLE, 1'b0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule